// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical beam position of a raster display, plus sync, blanking and active-video flags and a line-start pulse. All of them come from eight timing words and one control word written through a 16-bit register port. Each timing word names the *last* count that belongs to a region, not the region's length, so a region set to N spans N+1 clocks or lines. A counter runs from 0 up to its total-end value and then wraps.

The horizontal counter steps on a tick enable that comes from a fixed reference clock. The vertical counter steps whenever the horizontal counter wraps. Register writes land in a shadow copy. The shadow copy moves into the working copy only when a frame ends, so a frame is never produced with mixed timing. Inside the visible area the block also reports a zero-based X/Y position. A control bit for each axis mirrors that position, which serves a screen shown upside down or reversed.

Top module: `raster_tgen`

## Requirements
- R1: After reset, hcount and vcount are 0 and line_start is 0. The working timing equals the reset parameters, and both flip controls are off.
- R2: hcount rises by one on each clock with tick_en high and holds while tick_en is low. A tick at the horizontal total-end value returns it to 0.
- R3: vcount rises by one when hcount wraps. The wrap at the vertical total-end value returns it to 0.
- R4: hsync is 1 while hcount ≤ horizontal sync-end. vsync is 1 while vcount ≤ vertical sync-end.
- R5: hblank is 1 while hcount ≤ horizontal blank-end or hcount > horizontal screen-end, and vblank follows the same rule on vcount. When screen-end ≤ blank-end, the axis stays blanked for the whole line or frame.
- R6: active is 1 exactly when both hblank and vblank are 0.
- R7: line_start is 1 for the one clock that follows a horizontal wrap, and it coincides with hcount = 0.
- R8: A register write changes only the shadow copy. The shadow copy becomes the working timing on the clock where both counters wrap together, so the new timing starts with the next frame.
- R9: While active, xpos = hcount − hblank_end − 1 and ypos = vcount − vblank_end − 1. Outside the active area both are 0.
- R10: The control word is at byte offset 0x80. Bit 3 mirrors X and bit 4 mirrors Y: a mirrored X is (hscreen_end − hblank_end − 1) − unmirrored X, and Y is mirrored the same way. Like the timing words, the control word takes effect at the next frame.
- R11: The timing words sit at byte offsets 0x60/0x62/0x64/0x66 (horizontal sync-end, blank-end, screen-end, total-end) and 0x70/0x72/0x74/0x76 (the vertical set in the same order). Writes to any other offset, and control bits other than 3 and 4, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Fixed-reference tick; advances the horizontal counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| hcount | output | CW | Horizontal position |
| vcount | output | CW | Vertical position |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| active | output | 1 | Visible-area flag |
| line_start | output | 1 | One-clock pulse at the start of each line |
| xpos | output | CW | Active-area X, mirrored when enabled |
| ypos | output | CW | Active-area Y, mirrored when enabled |

## Verification
The bench builds the block with CW = 8 and small reset timing: horizontal 1/3/9/11 and vertical 0/1/5/6. A whole frame then lasts 84 ticks, so many frame boundaries and shadow commits fit in a short run. The bench reprograms the block to larger and to degenerate timings, among them screen-end equal to blank-end and a 41-line frame. A reference model predicts the output on every clock. That covers the frame-end commit, mirroring in both axes and ignored writes, and mid-frame writes are checked to have no effect until the wrap.

// File: rtl/raster_tgen_pkg.sv
package raster_tgen_pkg;

   localparam int unsigned RW = 16;

   localparam logic [7:0] OFS_H_BASE = 8'h60;
   localparam logic [7:0] OFS_V_BASE = 8'h70;
   localparam logic [7:0] OFS_CTRL   = 8'h80;
   localparam int unsigned CTRL_FLIPX_BIT = 3;
   localparam int unsigned CTRL_FLIPY_BIT = 4;
   localparam int unsigned NSLOT = 8;

   typedef struct packed {
      logic [RW-1:0] sync_end;
      logic [RW-1:0] blank_end;
      logic [RW-1:0] screen_end;
      logic [RW-1:0] total_end;
   } axis_cfg_t;

   // slots 0..3 horizontal, 4..7 vertical; each in sync/blank/screen/total order
   function automatic logic [7:0] slot_addr(input int unsigned idx);
      logic [7:0] base;
      base = (idx < 4) ? OFS_H_BASE : OFS_V_BASE;
      return base + 8'((idx % 4) * 2);
   endfunction

endpackage

// File: rtl/raster_tgen_regs.sv
module raster_tgen_regs
   import raster_tgen_pkg::*;
#(
   parameter int unsigned CW           = 11,
   parameter int unsigned H_SYNC_END   = 42,
   parameter int unsigned H_BLANK_END  = 111,
   parameter int unsigned H_SCREEN_END = 495,
   parameter int unsigned H_TOTAL_END  = 613,
   parameter int unsigned V_SYNC_END   = 3,
   parameter int unsigned V_BLANK_END  = 21,
   parameter int unsigned V_SCREEN_END = 245,
   parameter int unsigned V_TOTAL_END  = 262
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [7:0]    addr,
   input  logic [RW-1:0] wdata,
   input  logic          commit,
   output axis_cfg_t     h_cfg,
   output axis_cfg_t     v_cfg,
   output logic          flip_x,
   output logic          flip_y
);

   localparam logic [RW-1:0] MASK = RW'((32'd1 << CW) - 1);

   if (CW < 2 || CW > RW) begin : g_bad_cw
      $error("raster_tgen_regs: CW must lie in 2..16");
   end
   if (H_TOTAL_END >= (1 << CW) || V_TOTAL_END >= (1 << CW)) begin : g_bad_total
      $error("raster_tgen_regs: reset total does not fit the counter width");
   end

   function automatic logic [RW-1:0] reset_word(input int unsigned idx);
      case (idx)
         0: return RW'(H_SYNC_END);
         1: return RW'(H_BLANK_END);
         2: return RW'(H_SCREEN_END);
         3: return RW'(H_TOTAL_END);
         4: return RW'(V_SYNC_END);
         5: return RW'(V_BLANK_END);
         6: return RW'(V_SCREEN_END);
         default: return RW'(V_TOTAL_END);
      endcase
   endfunction

   logic [NSLOT-1:0][RW-1:0] shd_q, live_q;
   logic [1:0]               shd_ctl_q, live_ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSLOT; i++) begin
            shd_q[i]  <= reset_word(i) & MASK;
            live_q[i] <= reset_word(i) & MASK;
         end
         shd_ctl_q  <= '0;
         live_ctl_q <= '0;
      end else begin
         if (commit) begin
            live_q     <= shd_q;
            live_ctl_q <= shd_ctl_q;
         end
         if (we) begin
            for (int i = 0; i < NSLOT; i++) begin
               if (addr == slot_addr(i)) shd_q[i] <= wdata & MASK;
            end
            if (addr == OFS_CTRL)
               shd_ctl_q <= {wdata[CTRL_FLIPY_BIT], wdata[CTRL_FLIPX_BIT]};
         end
      end
   end

   assign h_cfg  = '{sync_end: live_q[0], blank_end: live_q[1],
                     screen_end: live_q[2], total_end: live_q[3]};
   assign v_cfg  = '{sync_end: live_q[4], blank_end: live_q[5],
                     screen_end: live_q[6], total_end: live_q[7]};
   assign flip_x = live_ctl_q[0];
   assign flip_y = live_ctl_q[1];

   AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(live_q) && $stable(live_ctl_q)));   // R8

endmodule

// File: rtl/raster_tgen_axis.sv
module raster_tgen_axis
   import raster_tgen_pkg::*;
#(
   parameter int unsigned CW      = 11,
   parameter bit          FLIP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  axis_cfg_t     cfg,
   input  logic          flip,
   output logic [CW-1:0] count,
   output logic          wrap,
   output logic          sync,
   output logic          blank,
   output logic [CW-1:0] coord
);

   logic [RW-1:0] cnt_w, raw_w, span_w, coord_w;
   logic [RW-1:0] unused_coord_hi;

   assign cnt_w = RW'(count);
   assign wrap  = adv && (cnt_w >= cfg.total_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (wrap) count <= '0;
      else if (adv)  count <= count + 1'b1;
   end

   assign sync   = (cnt_w <= cfg.sync_end);
   assign blank  = (cnt_w <= cfg.blank_end) || (cnt_w > cfg.screen_end);
   assign raw_w  = cnt_w - cfg.blank_end - 1'b1;
   assign span_w = cfg.screen_end - cfg.blank_end - 1'b1;

   if (FLIP_EN) begin : g_mirror
      assign coord_w = flip ? (span_w - raw_w) : raw_w;
   end else begin : g_plain
      logic unused_flip;
      assign unused_flip = flip;
      assign coord_w     = raw_w;
   end

   assign coord           = coord_w[CW-1:0];
   assign unused_coord_hi = coord_w;

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_w <= cfg.total_end);                                  // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(count));                                 // R2
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));                                  // R3
   AST_COORD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      !blank |-> (coord_w <= span_w));                          // R9

endmodule

// File: rtl/raster_tgen.sv
module raster_tgen
   import raster_tgen_pkg::*;
#(
   parameter int unsigned CW           = 11,
   parameter bit          FLIP_EN      = 1'b1,
   parameter int unsigned H_SYNC_END   = 42,
   parameter int unsigned H_BLANK_END  = 111,
   parameter int unsigned H_SCREEN_END = 495,
   parameter int unsigned H_TOTAL_END  = 613,
   parameter int unsigned V_SYNC_END   = 3,
   parameter int unsigned V_BLANK_END  = 21,
   parameter int unsigned V_SCREEN_END = 245,
   parameter int unsigned V_TOTAL_END  = 262
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          reg_we,
   input  logic [7:0]    reg_addr,
   input  logic [15:0]   reg_wdata,
   output logic [CW-1:0] hcount,
   output logic [CW-1:0] vcount,
   output logic          hsync,
   output logic          vsync,
   output logic          hblank,
   output logic          vblank,
   output logic          active,
   output logic          line_start,
   output logic [CW-1:0] xpos,
   output logic [CW-1:0] ypos
);

   axis_cfg_t     h_cfg, v_cfg;
   logic          flip_x, flip_y;
   logic          h_wrap, v_wrap, frame_end;
   logic [CW-1:0] h_coord, v_coord;

   assign frame_end = h_wrap && v_wrap;

   raster_tgen_regs #(
      .CW(CW),
      .H_SYNC_END(H_SYNC_END), .H_BLANK_END(H_BLANK_END),
      .H_SCREEN_END(H_SCREEN_END), .H_TOTAL_END(H_TOTAL_END),
      .V_SYNC_END(V_SYNC_END), .V_BLANK_END(V_BLANK_END),
      .V_SCREEN_END(V_SCREEN_END), .V_TOTAL_END(V_TOTAL_END)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .commit(frame_end), .h_cfg(h_cfg), .v_cfg(v_cfg),
      .flip_x(flip_x), .flip_y(flip_y)
   );

   raster_tgen_axis #(.CW(CW), .FLIP_EN(FLIP_EN)) u_haxis (
      .clk(clk), .rst_n(rst_n), .adv(tick_en), .cfg(h_cfg), .flip(flip_x),
      .count(hcount), .wrap(h_wrap), .sync(hsync), .blank(hblank), .coord(h_coord)
   );

   raster_tgen_axis #(.CW(CW), .FLIP_EN(FLIP_EN)) u_vaxis (
      .clk(clk), .rst_n(rst_n), .adv(h_wrap), .cfg(v_cfg), .flip(flip_y),
      .count(vcount), .wrap(v_wrap), .sync(vsync), .blank(vblank), .coord(v_coord)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_start <= 1'b0;
      else        line_start <= h_wrap;
   end

   assign active = !hblank && !vblank;
   assign xpos   = active ? h_coord : '0;
   assign ypos   = active ? v_coord : '0;

   AST_LINE_START_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> (hcount == '0));                           // R7
   AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (hcount == '0 && vcount == '0));            // R8
   AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (xpos == '0 && ypos == '0));                  // R9

endmodule

// File: tb/raster_tgen_bench.sv
module raster_tgen_bench;

   localparam int CW = 8;
   localparam int D_HS = 1, D_HB = 3, D_HE = 9, D_HT = 11;
   localparam int D_VS = 0, D_VB = 1, D_VE = 5, D_VT = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [CW-1:0] hcount, vcount, xpos, ypos;
   logic          hsync, vsync, hblank, vblank, active, line_start;

   always #4 clk = ~clk;   // 125 MHz

   raster_tgen #(
      .CW(CW), .FLIP_EN(1'b1),
      .H_SYNC_END(D_HS), .H_BLANK_END(D_HB), .H_SCREEN_END(D_HE), .H_TOTAL_END(D_HT),
      .V_SYNC_END(D_VS), .V_BLANK_END(D_VB), .V_SCREEN_END(D_VE), .V_TOTAL_END(D_VT)
   ) u_raster_tgen (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hcount(hcount), .vcount(vcount),
      .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank), .active(active),
      .line_start(line_start), .xpos(xpos), .ypos(ypos)
   );

   typedef struct {
      int h, v, x, y;
      bit hs, vs, hb, vb, act, ls;
      string tag;
   } exp_t;

   exp_t q[$];
   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 0;

   // reference model state: working and shadow timing, counters
   int mh = 0, mv = 0;
   int lv[8], sh[8];
   bit lfx = 0, lfy = 0, sfx = 0, sfy = 0, mls = 0;

   function automatic int slot_of(input logic [7:0] a);
      case (a)
         8'h60: return 0;  8'h62: return 1;  8'h64: return 2;  8'h66: return 3;
         8'h70: return 4;  8'h72: return 5;  8'h74: return 6;  8'h76: return 7;
         8'h80: return 8;
         default: return -1;
      endcase
   endfunction

   function automatic exp_t predict(input string tag);
      exp_t e;
      e.h  = mh;  e.v = mv;  e.ls = mls;  e.tag = tag;
      e.hs = (mh <= lv[0]);
      e.vs = (mv <= lv[4]);
      e.hb = (mh <= lv[1]) || (mh > lv[2]);
      e.vb = (mv <= lv[5]) || (mv > lv[6]);
      e.act = !e.hb && !e.vb;
      e.x = 0;  e.y = 0;
      if (e.act) begin
         e.x = lfx ? (lv[2] - lv[1] - 1) - (mh - lv[1] - 1) : (mh - lv[1] - 1);
         e.y = lfy ? (lv[6] - lv[5] - 1) - (mv - lv[5] - 1) : (mv - lv[5] - 1);
      end
      return e;
   endfunction

   // driver: applies one clock of stimulus and queues the expected result
   task automatic cyc(input bit tick, input bit we, input logic [7:0] a,
                      input logic [15:0] d, input string tag);
      bit wh, wv;
      int s;
      @(negedge clk);
      tick_en = tick;  reg_we = we;  reg_addr = a;  reg_wdata = d;
      wh = tick && (mh == lv[3]);
      wv = wh && (mv == lv[7]);
      if (wv) begin
         lv = sh;  lfx = sfx;  lfy = sfy;
      end
      if (we) begin
         s = slot_of(a);
         if (s >= 0 && s < 8) sh[s] = int'(d) & ((1 << CW) - 1);
         if (s == 8) begin sfx = d[3]; sfy = d[4]; end
      end
      if (tick) mh = wh ? 0 : mh + 1;
      if (wh)   mv = wv ? 0 : mv + 1;
      mls = wh;
      q.push_back(predict(tag));
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 16'h0000, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
      cyc(1'b1, 1'b1, a, d, tag);
   endtask

   task automatic chk(input string req, input string tag, input string what,
                      input int got, input int exp, inout bit bad);
      if (got != exp) begin
         $display("FAIL %s [%s] %s got %0d expected %0d", req, tag, what, got, exp);
         bad = 1'b1;
      end
   endtask

   // monitor: pops expected items and compares them 2 ns after the edge
   initial begin
      exp_t e;
      bit   bad;
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            bad = 1'b0;
            chk("R2", e.tag, "hcount", int'(hcount), e.h, bad);
            chk("R3", e.tag, "vcount", int'(vcount), e.v, bad);
            chk("R4", e.tag, "hsync", int'(hsync), int'(e.hs), bad);
            chk("R4", e.tag, "vsync", int'(vsync), int'(e.vs), bad);
            chk("R5", e.tag, "hblank", int'(hblank), int'(e.hb), bad);
            chk("R5", e.tag, "vblank", int'(vblank), int'(e.vb), bad);
            chk("R6", e.tag, "active", int'(active), int'(e.act), bad);
            chk("R7", e.tag, "line_start", int'(line_start), int'(e.ls), bad);
            chk("R9", e.tag, "xpos", int'(xpos), e.x, bad);
            chk("R9", e.tag, "ypos", int'(ypos), e.y, bad);
            vectors++;
            if (bad) miscompares++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog expired, expected run to finish");
         miscompares++;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      bit bad;
      lv = '{D_HS, D_HB, D_HE, D_HT, D_VS, D_VB, D_VE, D_VT};
      sh = lv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      bad = 1'b0;
      chk("R1", "reset", "hcount", int'(hcount), 0, bad);
      chk("R1", "reset", "vcount", int'(vcount), 0, bad);
      chk("R1", "reset", "line_start", int'(line_start), 0, bad);
      chk("R1", "reset", "hblank", int'(hblank), 1, bad);
      vectors++;
      if (bad) miscompares++;

      // R2/R3: one default frame at full tick rate
      run(90, "R2 free run");
      // R2: tick gaps hold the counters
      for (int i = 0; i < 60; i++) cyc(i[0], 1'b0, 8'h00, 16'h0000, "R2 gapped tick");

      // R8: new horizontal timing written mid-frame applies only at the frame wrap
      wr(8'h60, 16'd2,  "R8 h write");
      wr(8'h62, 16'd4,  "R8 h write");
      wr(8'h64, 16'd14, "R8 h write");
      wr(8'h66, 16'd17, "R8 h write");
      run(200, "R8 h commit");

      // R8: new vertical timing
      wr(8'h70, 16'd1, "R8 v write");
      wr(8'h72, 16'd2, "R8 v write");
      wr(8'h74, 16'd7, "R8 v write");
      wr(8'h76, 16'd9, "R8 v write");
      run(400, "R8 v commit");

      // R10: both axes mirrored; pixel-clock bits 2:0 set as well
      wr(8'h80, 16'h001F, "R10 flip xy");
      run(400, "R10 flip xy");

      // R11: unmapped offsets ignored; X-only mirror
      wr(8'h68, 16'd1,    "R11 unmapped");
      wr(8'h6E, 16'd3,    "R11 unmapped");
      wr(8'h78, 16'd0,    "R11 unmapped");
      wr(8'h61, 16'd0,    "R11 unmapped");
      wr(8'h80, 16'hFFE8, "R11 x only");
      run(400, "R11 x only");

      // R5: screen-end equal to blank-end keeps the line blanked
      wr(8'h62, 16'd5, "R5 degenerate");
      wr(8'h64, 16'd5, "R5 degenerate");
      run(400, "R5 degenerate");

      // R3: a taller frame, normal horizontal window restored
      wr(8'h64, 16'd14, "R3 tall");
      wr(8'h76, 16'd40, "R3 tall");
      wr(8'h74, 16'd35, "R3 tall");
      run(1600, "R3 tall frame");

      repeat (2) @(posedge clk);
      #3;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule